// File: doc/BRIEF.md
# Debug Command Enable Gate

This block sits between a JTAG TAP controller and an on-chip debug unit. On Update-IR it latches the debug command code. It then passes on an effective command that depends on a debug-enable input. While that enable is low, only three command codes take effect: bypass, ID read and debug-enable. Every other code is replaced by bypass. Reading the status register, applying control-register functions and the external debug-request input are all suppressed.

The raw enable is brought into the test-clock domain through a synchroniser, so a change takes effect one test-clock cycle later than a plain register would allow. The enable may legally change only in Test-Logic-Reset, Run-Test/Idle or Update-DR. A change seen in any other TAP state raises a one-cycle protocol-violation pulse. A register-select output tells external security logic that the debug-enable command is selected, so that logic can run its check before it raises the enable.

Top module: `dbg_cmd_gate`

## Requirements
- R1: After reset (rst_n low), eff_cmd is 7'h7F (bypass), and status_vis, ctrl_en, dbg_halt, regsel and proto_viol are all 0.
- R2: While the synchronised enable is 0, a latched code of 7'h02 (ID read), 7'h06 (debug enable) or 7'h7F (bypass) appears unchanged on eff_cmd.
- R3: While the synchronised enable is 0, any other latched code appears on eff_cmd as 7'h7F.
- R4: status_vis is 1 only while the synchronised enable is 1 and tap_state is Capture-IR (4'hE).
- R5: ctrl_en is 1 only while the synchronised enable is 1, eff_cmd is 7'h12 (control access) and tap_state is Update-DR (4'h5).
- R6: dbg_halt is 1 exactly when the synchronised enable is 1 and dbg_req_n is 0; with the enable at 0, dbg_req_n has no effect.
- R7: en_raw is sampled at a rising edge and takes effect on the outputs only after the following rising edge (two-flop synchroniser).
- R8: proto_viol pulses high for the cycle after a rising edge at which en_raw differs from its value at the previous edge while tap_state is not 4'hF, 4'hC or 4'h5.
- R9: regsel is 1 exactly while the latched command is 7'h06, regardless of the enable.
- R10: While the synchronised enable is 1, every latched code appears unchanged on eff_cmd.
- R11: An edge with tap_state at Test-Logic-Reset (4'hF) clears the synchronised enable and loads 7'h7F into the command latch.
- R12: cmd_code is latched only at a rising edge with tap_state at Update-IR (4'hD); at other edges it has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock |
| rst_n | input | 1 | Asynchronous active-low test reset |
| tap_state | input | 4 | Current TAP state code |
| cmd_code | input | 7 | Command code from the instruction shift path |
| en_raw | input | 1 | Unsynchronised debug enable |
| dbg_req_n | input | 1 | Active-low external debug request |
| eff_cmd | output | 7 | Effective command after gating |
| status_vis | output | 1 | Status register may be captured this cycle |
| ctrl_en | output | 1 | Control-register function may be applied |
| dbg_halt | output | 1 | Gated debug-entry request to the core |
| regsel | output | 1 | Debug-enable command selected, for security logic |
| proto_viol | output | 1 | Enable changed in an illegal TAP state |

## Verification
A control-register update and an external debug request can both take effect in the same cycle. The bench provokes this by driving dbg_req_n low in Update-DR with the control command latched and the enable synchronised. It then expects ctrl_en and dbg_halt high together. The same stimulus is repeated with the enable low, and both outputs must then stay 0.

// File: rtl/dbg_gate_pkg.sv
package dbg_gate_pkg;
  localparam int unsigned CMD_W = 7;

  localparam logic [3:0] ST_TLR   = 4'hF;
  localparam logic [3:0] ST_RTI   = 4'hC;
  localparam logic [3:0] ST_UPDR  = 4'h5;
  localparam logic [3:0] ST_CAPIR = 4'hE;
  localparam logic [3:0] ST_UPIR  = 4'hD;

  localparam logic [CMD_W-1:0] CODE_BYPASS = '1;
  localparam logic [CMD_W-1:0] CODE_IDRD   = 7'h02;
  localparam logic [CMD_W-1:0] CODE_DBGEN  = 7'h06;
  localparam logic [CMD_W-1:0] CODE_CTRL   = 7'h12;

  function automatic logic en_change_ok(input logic [3:0] st);
    return (st == ST_TLR) || (st == ST_RTI) || (st == ST_UPDR);
  endfunction

  function automatic logic code_allowed(input logic [CMD_W-1:0] c);
    return (c == CODE_BYPASS) || (c == CODE_IDRD) || (c == CODE_DBGEN);
  endfunction
endpackage

// File: rtl/dbg_en_sync.sv
module dbg_en_sync #(
  parameter int unsigned DEPTH = 2
) (
  input  logic tck,
  input  logic rst_n,
  input  logic tap_tlr,
  input  logic chg_legal,
  input  logic en_raw,
  output logic en_eff,
  output logic viol
);
  logic [DEPTH-1:0] stg_q, stg_d;
  logic             viol_q, viol_d;

  assign stg_d[0] = en_raw;

  generate
    for (genvar i = 1; i < DEPTH; i++) begin : g_stage
      assign stg_d[i] = tap_tlr ? 1'b0 : stg_q[i-1];
    end
  endgenerate

  always_comb begin
    viol_d = (en_raw ^ stg_q[0]) & ~chg_legal;
  end

  always_ff @(posedge tck or negedge rst_n) begin
    if (!rst_n) begin
      stg_q  <= '0;
      viol_q <= 1'b0;
    end else begin
      stg_q  <= stg_d;
      viol_q <= viol_d;
    end
  end

  assign en_eff = stg_q[DEPTH-1];
  assign viol   = viol_q;
endmodule

// File: rtl/dbg_ir_latch.sv
module dbg_ir_latch
  import dbg_gate_pkg::*;
#(
  parameter int unsigned W = CMD_W
) (
  input  logic         tck,
  input  logic         rst_n,
  input  logic         tap_tlr,
  input  logic         upd_ir,
  input  logic [W-1:0] cmd_in,
  output logic [W-1:0] cmd_q
);
  logic [W-1:0] cmd_d;
  logic         cmd_ce;

  always_comb begin
    cmd_ce = tap_tlr | upd_ir;
    cmd_d  = tap_tlr ? {W{1'b1}} : cmd_in;
  end

  always_ff @(posedge tck or negedge rst_n) begin
    if (!rst_n) begin
      cmd_q <= {W{1'b1}};
    end else if (cmd_ce) begin
      cmd_q <= cmd_d;
    end
  end
endmodule

// File: rtl/dbg_cmd_filter.sv
module dbg_cmd_filter
  import dbg_gate_pkg::*;
(
  input  logic             en_eff,
  input  logic [CMD_W-1:0] cmd_q,
  input  logic [3:0]       tap_state,
  input  logic             dbg_req_n,
  output logic [CMD_W-1:0] eff_cmd,
  output logic             status_vis,
  output logic             ctrl_en,
  output logic             dbg_halt,
  output logic             regsel
);
  always_comb begin
    if (en_eff || code_allowed(cmd_q)) eff_cmd = cmd_q;
    else                               eff_cmd = CODE_BYPASS;
    status_vis = en_eff & (tap_state == ST_CAPIR);
    ctrl_en    = en_eff & (tap_state == ST_UPDR) & (eff_cmd == CODE_CTRL);
    dbg_halt   = en_eff & ~dbg_req_n;
    regsel     = (cmd_q == CODE_DBGEN);
  end
endmodule

// File: rtl/dbg_cmd_gate.sv
module dbg_cmd_gate
  import dbg_gate_pkg::*;
#(
  parameter int unsigned SYNC_DEPTH = 2
) (
  input  logic             tck,
  input  logic             rst_n,
  input  logic [3:0]       tap_state,
  input  logic [CMD_W-1:0] cmd_code,
  input  logic             en_raw,
  input  logic             dbg_req_n,
  output logic [CMD_W-1:0] eff_cmd,
  output logic             status_vis,
  output logic             ctrl_en,
  output logic             dbg_halt,
  output logic             regsel,
  output logic             proto_viol
);
  logic             tap_tlr;
  logic             upd_ir;
  logic             chg_legal;
  logic             en_eff;
  logic [CMD_W-1:0] cmd_q;

  assign tap_tlr   = (tap_state == ST_TLR);
  assign upd_ir    = (tap_state == ST_UPIR);
  assign chg_legal = en_change_ok(tap_state);

  dbg_en_sync #(.DEPTH(SYNC_DEPTH)) u_sync (
    .tck(tck), .rst_n(rst_n), .tap_tlr(tap_tlr), .chg_legal(chg_legal),
    .en_raw(en_raw), .en_eff(en_eff), .viol(proto_viol)
  );

  dbg_ir_latch #(.W(CMD_W)) u_ir (
    .tck(tck), .rst_n(rst_n), .tap_tlr(tap_tlr), .upd_ir(upd_ir),
    .cmd_in(cmd_code), .cmd_q(cmd_q)
  );

  dbg_cmd_filter u_filt (
    .en_eff(en_eff), .cmd_q(cmd_q), .tap_state(tap_state), .dbg_req_n(dbg_req_n),
    .eff_cmd(eff_cmd), .status_vis(status_vis), .ctrl_en(ctrl_en),
    .dbg_halt(dbg_halt), .regsel(regsel)
  );
endmodule

// File: rtl/dbg_cmd_gate_chk.sv
module dbg_cmd_gate_chk
  import dbg_gate_pkg::*;
#(
  parameter int unsigned SYNC_DEPTH = 2
) (
  input logic             tck,
  input logic             rst_n,
  input logic [3:0]       tap_state,
  input logic             en_raw,
  input logic             en_eff,
  input logic [CMD_W-1:0] cmd_q,
  input logic [CMD_W-1:0] eff_cmd,
  input logic             status_vis,
  input logic             ctrl_en,
  input logic             dbg_halt,
  input logic             proto_viol
);
  assert_whitelist_R3: assert property (@(posedge tck) disable iff (!rst_n)
    !en_eff |-> code_allowed(eff_cmd));

  assert_status_hidden_R4: assert property (@(posedge tck) disable iff (!rst_n)
    status_vis |-> (en_eff && tap_state == ST_CAPIR));

  assert_ctrl_gated_R5: assert property (@(posedge tck) disable iff (!rst_n)
    ctrl_en |-> (en_eff && tap_state == ST_UPDR));

  assert_req_ignored_R6: assert property (@(posedge tck) disable iff (!rst_n)
    !en_eff |-> !dbg_halt);

  assert_viol_state_R8: assert property (@(posedge tck) disable iff (!rst_n)
    proto_viol |-> !en_change_ok($past(tap_state)));

  assert_tlr_clear_R11: assert property (@(posedge tck) disable iff (!rst_n)
    (tap_state == ST_TLR) |=> (!en_eff && cmd_q == CODE_BYPASS));

  assert_latch_hold_R12: assert property (@(posedge tck) disable iff (!rst_n)
    (tap_state != ST_UPIR && tap_state != ST_TLR) |=> $stable(cmd_q));

  generate
    if (SYNC_DEPTH == 2) begin : g_lat
      assert_sync_latency_R7: assert property (@(posedge tck) disable iff (!rst_n)
        $rose(en_eff) |-> $past(en_raw));
    end
  endgenerate
endmodule

bind dbg_cmd_gate dbg_cmd_gate_chk #(.SYNC_DEPTH(SYNC_DEPTH)) u_chk (
  .tck(tck), .rst_n(rst_n), .tap_state(tap_state), .en_raw(en_raw),
  .en_eff(en_eff), .cmd_q(cmd_q), .eff_cmd(eff_cmd), .status_vis(status_vis),
  .ctrl_en(ctrl_en), .dbg_halt(dbg_halt), .proto_viol(proto_viol)
);

// File: tb/dbg_cmd_gate_tb.sv
`timescale 1ns/1ps
module dbg_cmd_gate_tb;
  import dbg_gate_pkg::*;

  typedef struct packed {
    logic [6:0] cmd;
    logic       st, ct, ha, rs, vi;
  } exp_t;

  logic       tck = 1'b0;
  logic       rst_n;
  logic [3:0] tap_state;
  logic [6:0] cmd_code;
  logic       en_raw, dbg_req_n;
  logic [6:0] eff_cmd;
  logic       status_vis, ctrl_en, dbg_halt, regsel, proto_viol;

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;
  bit done   = 1'b0;

  exp_t  exp_q[$];
  string tag_q[$];

  logic       ref_q1, ref_en, ref_viol;
  logic [6:0] ref_cmd;

  always #2.5 tck = ~tck;

  dbg_cmd_gate u_dut (
    .tck(tck), .rst_n(rst_n), .tap_state(tap_state), .cmd_code(cmd_code),
    .en_raw(en_raw), .dbg_req_n(dbg_req_n), .eff_cmd(eff_cmd),
    .status_vis(status_vis), .ctrl_en(ctrl_en), .dbg_halt(dbg_halt),
    .regsel(regsel), .proto_viol(proto_viol)
  );

  task automatic step(input logic [3:0] st, input logic [6:0] cmd,
                      input logic en, input logic rq, input string tag);
    exp_t e;
    @(negedge tck);
    tap_state = st; cmd_code = cmd; en_raw = en; dbg_req_n = rq;
    e.cmd = (ref_en || ref_cmd == 7'h02 || ref_cmd == 7'h06 || ref_cmd == 7'h7F)
            ? ref_cmd : 7'h7F;
    e.st  = ref_en && (st == 4'hE);
    e.ct  = ref_en && (st == 4'h5) && (e.cmd == 7'h12);
    e.ha  = ref_en && !rq;
    e.rs  = (ref_cmd == 7'h06);
    e.vi  = ref_viol;
    exp_q.push_back(e);
    tag_q.push_back(tag);
    ref_viol = (en != ref_q1) && !(st == 4'hF || st == 4'hC || st == 4'h5);
    ref_en   = (st == 4'hF) ? 1'b0 : ref_q1;
    ref_q1   = en;
    if (st == 4'hF)      ref_cmd = 7'h7F;
    else if (st == 4'hD) ref_cmd = cmd;
  endtask

  initial begin : monitor
    forever begin
      @(negedge tck);
      #1;
      if (exp_q.size() > 0) begin
        exp_t  e;
        string t;
        exp_t  a;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        a = '{eff_cmd, status_vis, ctrl_en, dbg_halt, regsel, proto_viol};
        checks++;
        if (a !== e) begin
          fails++;
          $display("FAIL %s: actual cmd=%h st=%b ct=%b ha=%b rs=%b vi=%b expected cmd=%h st=%b ct=%b ha=%b rs=%b vi=%b",
                   t, a.cmd, a.st, a.ct, a.ha, a.rs, a.vi,
                   e.cmd, e.st, e.ct, e.ha, e.rs, e.vi);
        end
      end
    end
  end

  always @(posedge tck) begin
    cyc <= cyc + 1;
    if (cyc == 20000 && !done) begin
      fails++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin : driver
    rst_n = 1'b0; tap_state = 4'hF; cmd_code = 7'h00; en_raw = 1'b0; dbg_req_n = 1'b1;
    ref_q1 = 1'b0; ref_en = 1'b0; ref_viol = 1'b0; ref_cmd = 7'h7F;
    repeat (3) @(negedge tck);
    rst_n = 1'b1;
    step(4'hC, 7'h00, 0, 1, "R1 reset state");
    step(4'hD, 7'h02, 0, 1, "R12 latch id code");
    step(4'hC, 7'h05, 0, 1, "R2 id passes while disabled");
    step(4'hC, 7'h00, 0, 1, "R12 code ignored outside Update-IR");
    step(4'hD, 7'h06, 0, 1, "R12 latch enable code");
    step(4'hC, 7'h00, 0, 1, "R9 regsel with R2 enable code");
    step(4'hD, 7'h12, 0, 1, "R9 regsel still set");
    step(4'hC, 7'h00, 0, 0, "R3 control code -> bypass, R6 request ignored");
    step(4'h5, 7'h00, 0, 0, "R5 R6 ctrl and halt blocked together");
    step(4'hE, 7'h00, 0, 1, "R4 status hidden");
    step(4'hC, 7'h00, 1, 1, "R7 enable raised");
    step(4'hC, 7'h00, 1, 1, "R7 enable still gated");
    step(4'hC, 7'h00, 1, 1, "R7 R10 enable in effect");
    step(4'h5, 7'h00, 1, 1, "R5 ctrl applied");
    step(4'h5, 7'h00, 1, 0, "R5 R6 ctrl and halt together");
    step(4'hE, 7'h00, 1, 1, "R4 status visible");
    step(4'hC, 7'h00, 1, 0, "R6 halt request");
    step(4'hD, 7'h33, 1, 1, "R10 latch full code");
    step(4'hC, 7'h00, 1, 1, "R10 full code passes");
    step(4'h2, 7'h00, 0, 1, "R8 illegal change");
    step(4'h2, 7'h00, 0, 1, "R8 flag pulse");
    step(4'hC, 7'h00, 0, 1, "R8 flag clears");
    step(4'hC, 7'h00, 1, 1, "R8 legal change no flag");
    step(4'hC, 7'h00, 1, 1, "R10 re-enabled");
    step(4'hD, 7'h33, 1, 1, "R10 relatch");
    step(4'hF, 7'h00, 1, 1, "R11 enter reset state");
    step(4'hC, 7'h00, 1, 1, "R11 enable and command cleared");
    step(4'hC, 7'h00, 1, 1, "R11 enable returns");
    repeat (3) @(negedge tck);
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule